// File: doc/BRIEF.md
# NAND Flash Bus Front End

This block is the device-side end of a NAND-style flash bus. It watches the chip enable, command latch, address latch, write and read strobes together with an 8-bit data bus. Each write strobe is sorted into one of four outcomes: a command capture, an address byte, a data byte, or a refused illegal combination. All strobes and bus bits pass through a synchroniser into the system clock domain first, and edges are found on the synchronised copies. Every capture happens on a rising edge of the write strobe.

Address bytes arrive as column bytes first and row bytes after them. A column counter holds the page position. Data writes and read strobes both step it forward. Read data comes out of a small page buffer through a registered output with a separate enable. After power comes up, or after the supply indication drops and returns, a recovery timer counts a fixed time in clock cycles. Until that time has passed, every strobe is ignored. While the memory reports busy, the device stays selected even if chip enable is released.

Top module: `nand_cmd_front`

## Requirements
- R1: After reset, and whenever `supply_ok` is low, `ready` is low. `ready` goes high once `supply_ok` has been high for RECOVERY_CYCLES consecutive clocks (CLK_KHZ*RECOVERY_US/1000, 2500 by default). While `ready` is low, no write or read strobe changes any register.
- R2: A write-strobe rising edge with `cle`=1, `ale`=0 and `ce_n`=0 loads the bus byte into `cmd_code`. It pulses `cmd_valid` high for exactly one clock and clears `addr_count` to 0.
- R3: A write-strobe rising edge with `ale`=1 and `cle`=0 stores the bus byte as an address byte and increments `addr_count`. Byte 0 goes to `col_addr[7:0]` and byte 1 to `col_addr[15:8]`. Bytes 2, 3 and 4 go to `row_addr[7:0]`, `[15:8]` and `[23:16]`. Once `addr_count` reaches 5, further address bytes are ignored.
- R4: A write-strobe rising edge with `cle`=0 and `ale`=0 writes the bus byte into the page buffer at `col_addr` modulo PAGE_BYTES, then increments `col_addr` by one.
- R5: A write-strobe rising edge with `cle`=1 and `ale`=1 leaves `cmd_code`, `col_addr`, `row_addr` and `addr_count` unchanged. It sets `illegal_err`, which stays set until reset.
- R6: Each falling edge of `re_n` while `ce_n`=0 drives the buffer byte at the current column onto `io_out`, then increments `col_addr` by one.
- R7: `io_oe` is high only while both `ce_n` and `re_n` are low. The bus is released (`io_oe`=0) whenever either of them is high.
- R8: `selected` is high while `ce_n` is low or `busy` is high. When `ce_n` goes high during busy, the device stays selected; it drops to standby only once `busy` is low.
- R9: Write and read strobe edges that occur while `ce_n` is high change neither the column, the captured command nor the output enable.
- R10: Strobe and bus inputs act after SYNC_STAGES+1 clocks. Holding each strobe level for four clocks is enough for every capture at the default SYNC_STAGES=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_ok | input | 1 | Supply good; low restarts the recovery timer |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe, capture on rising edge |
| re_n | input | 1 | Read strobe, advance on falling edge |
| busy | input | 1 | Array busy indication |
| io_in | input | 8 | Bus value driven toward the device |
| io_out | output | 8 | Read data driven from the device |
| io_oe | output | 1 | Output enable for io_out |
| cmd_code | output | 8 | Last captured command byte |
| cmd_valid | output | 1 | One-clock pulse per command capture |
| col_addr | output | 16 | Column counter |
| row_addr | output | 24 | Collected row address |
| addr_count | output | 3 | Address bytes taken since the last command |
| illegal_err | output | 1 | Sticky flag for a write with both latch enables high |
| ready | output | 1 | Recovery window has elapsed |
| selected | output | 1 | Device is active (not in standby) |

## Verification
The bench issues a command during the recovery window. A design that ignored the timer would update `cmd_code` there. A sixth address byte must leave the row untouched; a design without saturation would wrap the count or overwrite a column byte. A write with both latch enables high must be refused. Logic that let the command latch win would change `cmd_code` instead of raising only the error flag. Strobes are also toggled with chip enable high, and chip enable is released while busy. Those two cases catch a column counter that moves with the device deselected, and a `selected` output that ignores busy.

// File: rtl/nfi_pkg.sv
package nfi_pkg;

   typedef enum logic [1:0] {
      LK_DATA = 2'b00,
      LK_ADDR = 2'b01,
      LK_CMD  = 2'b10,
      LK_BAD  = 2'b11
   } latch_kind_e;

   function automatic latch_kind_e classify(input logic cle_v, input logic ale_v);
      return latch_kind_e'({cle_v, ale_v});
   endfunction

endpackage

// File: rtl/nfi_sync.sv
module nfi_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("nfi_sync needs at least two stages");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/nfi_recovery_timer.sv
module nfi_recovery_timer #(
   parameter int LIMIT = 2500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok,
   output logic ready
);
   localparam int TW = $clog2(LIMIT + 1);

   generate
      if (LIMIT < 1) begin : g_bad
         $error("recovery limit must be at least one cycle");
      end
   endgenerate

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !supply_ok) cnt_q <= '0;
      else if (cnt_q != TW'(LIMIT)) cnt_q <= cnt_q + TW'(1);
   end

   assign ready = (cnt_q == TW'(LIMIT));
endmodule

// File: rtl/nfi_addr_seq.sv
module nfi_addr_seq #(
   parameter int COL_BYTES = 2,
   parameter int ROW_BYTES = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cmd_ev,
   input  logic                      addr_ev,
   input  logic                      step_ev,
   input  logic [7:0]                byte_in,
   output logic [8*COL_BYTES-1:0]    col,
   output logic [8*ROW_BYTES-1:0]    row,
   output logic [$clog2(COL_BYTES+ROW_BYTES+1)-1:0] count
);
   localparam int COL_W = 8 * COL_BYTES;
   localparam int TOTAL = COL_BYTES + ROW_BYTES;
   localparam int CNT_W = $clog2(TOTAL + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [COL_W-1:0] col_q, col_nxt;
   logic             take;

   assign take = addr_ev && (cnt_q != CNT_W'(TOTAL));

   always_comb begin
      col_nxt = col_q;
      if (step_ev) col_nxt = col_q + COL_W'(1);
      for (int i = 0; i < COL_BYTES; i++) begin
         if (take && cnt_q == CNT_W'(i)) col_nxt[8*i +: 8] = byte_in;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_q <= '0;
         cnt_q <= '0;
      end else begin
         col_q <= col_nxt;
         if (cmd_ev)    cnt_q <= '0;
         else if (take) cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   generate
      for (genvar j = 0; j < ROW_BYTES; j++) begin : g_row
         logic [7:0] lane_q;
         always_ff @(posedge clk) begin
            if (!rst_n) lane_q <= '0;
            else if (take && cnt_q == CNT_W'(COL_BYTES + j)) lane_q <= byte_in;
         end
         assign row[8*j +: 8] = lane_q;
      end
   endgenerate

   assign col   = col_q;
   assign count = cnt_q;
endmodule

// File: rtl/nfi_page_buf.sv
module nfi_page_buf #(
   parameter int DEPTH = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [$clog2(DEPTH)-1:0] idx,
   input  logic [7:0]               wr_data,
   input  logic                     rd_en,
   output logic [7:0]               rd_data
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[idx] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= mem[idx];
   end
endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front #(
   parameter int CLK_KHZ     = 250000,
   parameter int RECOVERY_US = 10,
   parameter int SYNC_STAGES = 2,
   parameter int COL_BYTES   = 2,
   parameter int ROW_BYTES   = 3,
   parameter int PAGE_BYTES  = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  supply_ok,
   input  logic                  ce_n,
   input  logic                  cle,
   input  logic                  ale,
   input  logic                  we_n,
   input  logic                  re_n,
   input  logic                  busy,
   input  logic [7:0]            io_in,
   output logic [7:0]            io_out,
   output logic                  io_oe,
   output logic [7:0]            cmd_code,
   output logic                  cmd_valid,
   output logic [8*COL_BYTES-1:0] col_addr,
   output logic [8*ROW_BYTES-1:0] row_addr,
   output logic [$clog2(COL_BYTES+ROW_BYTES+1)-1:0] addr_count,
   output logic                  illegal_err,
   output logic                  ready,
   output logic                  selected
);
   import nfi_pkg::*;

   localparam int COL_W           = 8 * COL_BYTES;
   localparam int ADDR_BYTES      = COL_BYTES + ROW_BYTES;
   localparam int IDX_W           = $clog2(PAGE_BYTES);
   localparam int RECOVERY_CYCLES = CLK_KHZ * RECOVERY_US / 1000;

   generate
      if ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0 || PAGE_BYTES < 2) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two");
      end
      if (IDX_W > COL_W) begin : g_bad_col
         $error("column counter too narrow for the page buffer");
      end
      if (COL_BYTES < 1 || ROW_BYTES < 1) begin : g_bad_addr
         $error("need at least one column and one row byte");
      end
   endgenerate

   // synchronised strobes {ce_n, cle, ale, we_n, re_n}
   logic [4:0] strb_s;
   logic [7:0] io_s;
   logic       ce_s, cle_s, ale_s, we_s, re_s;
   logic       we_d, re_d;

   nfi_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b10011)) u_strb_sync (
      .clk(clk), .rst_n(rst_n), .d({ce_n, cle, ale, we_n, re_n}), .q(strb_s)
   );
   nfi_sync #(.W(8), .STAGES(SYNC_STAGES), .RST_VAL(8'h00)) u_bus_sync (
      .clk(clk), .rst_n(rst_n), .d(io_in), .q(io_s)
   );

   assign {ce_s, cle_s, ale_s, we_s, re_s} = strb_s;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         we_d <= 1'b1;
         re_d <= 1'b1;
      end else begin
         we_d <= we_s;
         re_d <= re_s;
      end
   end

   logic        active, we_rise, re_fall;
   latch_kind_e kind;
   logic        cmd_ev, addr_ev, data_ev, bad_ev, rd_ev;

   assign active  = ready && !ce_s;
   assign we_rise = we_s && !we_d;
   assign re_fall = !re_s && re_d;
   assign kind    = classify(cle_s, ale_s);

   assign cmd_ev  = active && we_rise && kind == LK_CMD;
   assign addr_ev = active && we_rise && kind == LK_ADDR;
   assign data_ev = active && we_rise && kind == LK_DATA;
   assign bad_ev  = active && we_rise && kind == LK_BAD;
   assign rd_ev   = active && re_fall;

   nfi_recovery_timer #(.LIMIT(RECOVERY_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ready(ready)
   );

   nfi_addr_seq #(.COL_BYTES(COL_BYTES), .ROW_BYTES(ROW_BYTES)) u_addr (
      .clk(clk), .rst_n(rst_n), .cmd_ev(cmd_ev), .addr_ev(addr_ev),
      .step_ev(data_ev || rd_ev), .byte_in(io_s),
      .col(col_addr), .row(row_addr), .count(addr_count)
   );

   nfi_page_buf #(.DEPTH(PAGE_BYTES)) u_buf (
      .clk(clk), .rst_n(rst_n), .wr_en(data_ev), .idx(col_addr[IDX_W-1:0]),
      .wr_data(io_s), .rd_en(rd_ev), .rd_data(io_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_code    <= '0;
         cmd_valid   <= 1'b0;
         illegal_err <= 1'b0;
      end else begin
         cmd_valid <= cmd_ev;
         if (cmd_ev) cmd_code    <= io_s;
         if (bad_ev) illegal_err <= 1'b1;
      end
   end

   assign io_oe    = !ce_s && !re_s;
   assign selected = !ce_s || busy;

endmodule

// File: rtl/nfi_checker.sv
module nfi_checker #(
   parameter int RECOVERY_CYCLES = 2500,
   parameter int ADDR_BYTES      = 5,
   parameter int CNT_W           = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             supply_ok,
   input logic             ready,
   input logic             cmd_valid,
   input logic [7:0]       cmd_code,
   input logic [CNT_W-1:0] addr_count,
   input logic             illegal_err,
   input logic             io_oe,
   input logic             selected
);
   int unsigned good_run;

   always_ff @(posedge clk) begin
      if (!rst_n || !supply_ok) good_run <= 0;
      else if (good_run < RECOVERY_CYCLES) good_run <= good_run + 1;
   end

   p_ready_after_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> good_run >= RECOVERY_CYCLES);

   p_quiet_before_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |=> $stable(cmd_code));

   p_cmd_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

   p_cmd_clears_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> addr_count == '0);

   p_count_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
      addr_count <= CNT_W'(ADDR_BYTES));

   p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_err |=> illegal_err);

   p_oe_needs_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
      io_oe |-> selected);
endmodule

bind nand_cmd_front nfi_checker #(
   .RECOVERY_CYCLES(RECOVERY_CYCLES),
   .ADDR_BYTES(ADDR_BYTES),
   .CNT_W($clog2(ADDR_BYTES + 1))
) u_nfi_checker (
   .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ready(ready),
   .cmd_valid(cmd_valid), .cmd_code(cmd_code), .addr_count(addr_count),
   .illegal_err(illegal_err), .io_oe(io_oe), .selected(selected)
);

// File: tb/tb_nand_cmd_front.sv
module tb_nand_cmd_front;
   localparam int LIMIT = 250000 * 10 / 1000;

   logic        clk = 1'b0;
   logic        rst_n, supply_ok, ce_n, cle, ale, we_n, re_n, busy;
   logic [7:0]  io_in;
   logic [7:0]  io_out, cmd_code;
   logic        io_oe, cmd_valid, illegal_err, ready, selected;
   logic [15:0] col_addr;
   logic [23:0] row_addr;
   logic [2:0]  addr_count;

   int errors = 0;
   int checks = 0;
   int cyc    = 0;
   int n_cmd  = 0;

   always #2 clk = ~clk;

   nand_cmd_front dut (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ce_n(ce_n), .cle(cle),
      .ale(ale), .we_n(we_n), .re_n(re_n), .busy(busy), .io_in(io_in),
      .io_out(io_out), .io_oe(io_oe), .cmd_code(cmd_code), .cmd_valid(cmd_valid),
      .col_addr(col_addr), .row_addr(row_addr), .addr_count(addr_count),
      .illegal_err(illegal_err), .ready(ready), .selected(selected)
   );

   always @(posedge clk) begin
      if (rst_n) cyc <= cyc + 1;
      if (cmd_valid) n_cmd <= n_cmd + 1;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   // kind: 0 data, 1 address, 2 command, 3 both enables
   task automatic wr(input logic [1:0] kind, input logic [7:0] b);
      cle = kind[1]; ale = kind[0]; io_in = b; we_n = 1'b0;
      hold(4);
      we_n = 1'b1;
      hold(4);
      cle = 1'b0; ale = 1'b0;
   endtask

   task automatic rd_byte(input logic [7:0] exp, input string req);
      re_n = 1'b0;
      hold(4);
      check({req, " read byte"}, {24'h0, io_out}, {24'h0, exp});
      check("R7 oe while reading", {31'h0, io_oe}, 32'h1);
      re_n = 1'b1;
      hold(4);
      check("R7 oe released", {31'h0, io_oe}, 32'h0);
   endtask

   typedef struct packed {
      logic [1:0]  kind;
      logic [7:0]  b;
      logic [7:0]  exp_cmd;
      logic [15:0] exp_col;
      logic [2:0]  exp_cnt;
   } vec_t;

   localparam vec_t TBL [12] = '{
      '{2'd2, 8'h80, 8'h80, 16'h0000, 3'd0},  // R2 command
      '{2'd1, 8'h04, 8'h80, 16'h0004, 3'd1},  // R3 column low
      '{2'd1, 8'h00, 8'h80, 16'h0004, 3'd2},  // R3 column high
      '{2'd1, 8'h11, 8'h80, 16'h0004, 3'd3},  // R3 row bytes
      '{2'd1, 8'h22, 8'h80, 16'h0004, 3'd4},
      '{2'd1, 8'h33, 8'h80, 16'h0004, 3'd5},
      '{2'd1, 8'h44, 8'h80, 16'h0004, 3'd5},  // R3 extra byte ignored
      '{2'd0, 8'hA5, 8'h80, 16'h0005, 3'd5},  // R4 data
      '{2'd0, 8'h5A, 8'h80, 16'h0006, 3'd5},  // R4 data
      '{2'd3, 8'hFF, 8'h80, 16'h0006, 3'd5},  // R5 illegal ignored
      '{2'd2, 8'h10, 8'h10, 16'h0006, 3'd0},  // R2 restart sequence
      '{2'd1, 8'h07, 8'h10, 16'h0007, 3'd1}   // R3 column low again
   };

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0; supply_ok = 1'b1; ce_n = 1'b1; cle = 1'b0; ale = 1'b0;
      we_n = 1'b1; re_n = 1'b1; busy = 1'b0; io_in = 8'h00;
      hold(5);
      check("R1 ready in reset", {31'h0, ready}, 32'h0);
      check("R7 oe in reset", {31'h0, io_oe}, 32'h0);
      check("R2 cmd in reset", {24'h0, cmd_code}, 32'h0);
      check("R5 err in reset", {31'h0, illegal_err}, 32'h0);
      check("R8 standby in reset", {31'h0, selected}, 32'h0);
      rst_n = 1'b1;

      // R1: command during recovery is ignored
      ce_n = 1'b0;
      hold(4);
      wr(2'd2, 8'h55);
      check("R1 cmd ignored during recovery", {24'h0, cmd_code}, 32'h0);
      check("R1 no cmd pulse during recovery", n_cmd, 0);
      while (cyc < LIMIT - 5) @(negedge clk);
      check("R1 not ready before window", {31'h0, ready}, 32'h0);
      while (cyc < LIMIT + 5) @(negedge clk);
      check("R1 ready after window", {31'h0, ready}, 32'h1);

      // table walk: R2 R3 R4 R5 R10
      for (int i = 0; i < 12; i++) begin
         wr(TBL[i].kind, TBL[i].b);
         check($sformatf("R2 cmd vec%0d", i), {24'h0, cmd_code}, {24'h0, TBL[i].exp_cmd});
         check($sformatf("R3 col vec%0d", i), {16'h0, col_addr}, {16'h0, TBL[i].exp_col});
         check($sformatf("R3 count vec%0d", i), {29'h0, addr_count}, {29'h0, TBL[i].exp_cnt});
      end
      check("R3 row bytes", {8'h0, row_addr}, 32'h00332211);
      check("R5 error flag set", {31'h0, illegal_err}, 32'h1);
      check("R2 one pulse per command", n_cmd, 2);

      // R6: reposition column to 4 and read back
      wr(2'd2, 8'h00);
      wr(2'd1, 8'h04);
      wr(2'd1, 8'h00);
      check("R6 column reloaded", {16'h0, col_addr}, 32'h4);
      rd_byte(8'hA5, "R6 first");
      rd_byte(8'h5A, "R6 second");
      check("R6 column stepped", {16'h0, col_addr}, 32'h6);

      // R9: strobes with chip enable high
      ce_n = 1'b1;
      hold(4);
      wr(2'd0, 8'hEE);
      wr(2'd2, 8'h99);
      check("R9 data ignored when deselected", {16'h0, col_addr}, 32'h6);
      check("R9 cmd ignored when deselected", {24'h0, cmd_code}, 32'h00);
      re_n = 1'b0;
      hold(4);
      check("R9 R7 oe off when deselected", {31'h0, io_oe}, 32'h0);
      re_n = 1'b1;
      hold(4);
      check("R9 read ignored when deselected", {16'h0, col_addr}, 32'h6);

      // R8: busy keeps selection
      check("R8 standby when idle", {31'h0, selected}, 32'h0);
      busy = 1'b1;
      hold(1);
      check("R8 selected while busy", {31'h0, selected}, 32'h1);
      busy = 1'b0;
      hold(1);
      check("R8 standby after busy", {31'h0, selected}, 32'h0);

      // R1: supply drop restarts recovery
      ce_n = 1'b0;
      supply_ok = 1'b0;
      hold(3);
      check("R1 ready low on supply drop", {31'h0, ready}, 32'h0);
      supply_ok = 1'b1;
      wr(2'd2, 8'h77);
      check("R1 cmd ignored after supply drop", {24'h0, cmd_code}, 32'h00);
      check("R5 error still held", {31'h0, illegal_err}, 32'h1);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule